// File: doc/BRIEF.md
# Byte Ring Buffer with Automatic XON/XOFF Pacing

This block is a byte queue that sits between a serial receiver and whatever consumes the received stream. It is built as a circular store. A read pointer marks the oldest byte, a write pointer marks the next free slot, and a separate occupancy counter tracks how many bytes are held. The pointers wrap around the store on their own.

The buffer also paces the remote sender. Two runtime thresholds are supplied: an upper mark and a lower mark, with the lower mark strictly below the upper. When the fill level climbs to the upper mark, the block raises a one-cycle request that carries the pause character 0x13. The transmit path is expected to send that character to the host. Once the fill level has drained to the lower mark, the block raises a request that carries the resume character 0x11. A latched "paused" state gives the hysteresis, so each excursion produces exactly one pause request and exactly one resume request.

With the default parameter the store has 256 slots, and 255 of them can be used. One slot is always left empty so that "full" can be told apart from "empty". A write into a full buffer is dropped and sets a sticky overflow flag. A read from an empty buffer leaves the buffer unchanged.

Top module: `rb_xonxoff_fifo`

## Requirements
- R1: While reset is high and in the first cycle after it, empty_o=1, full_o=0, count_o=0, ovf_o=0 and ctl_req_o=0.
- R2: Bytes come out in the order they were written. rd_data_o is registered: it shows the byte taken by an accepted read in the cycle after the read strobe. The storage pointers wrap modulo 2**ADDR_W.
- R3: count_o goes up by one on an accepted write and down by one on an accepted read. It stays the same when a write and a read are both accepted in the same cycle.
- R4: empty_o is 1 exactly when count_o is 0. full_o is 1 exactly when count_o is 2**ADDR_W-1, so one slot always stays unused.
- R5: A write strobe while full_o=1 is dropped, even if a read is accepted in the same cycle. It sets ovf_o, and ovf_o stays 1 until reset.
- R6: A read strobe while empty_o=1 is ignored. rd_data_o keeps its last value, and count_o does not change.
- R7: When the block is not paused and the registered count_o is at or above hi_mark_i at a clock edge, then after that edge ctl_req_o is 1 for one cycle with ctl_byte_o=0x13, and the block enters the paused state.
- R8: When the block is paused and the registered count_o is at or below lo_mark_i at a clock edge, then after that edge ctl_req_o is 1 for one cycle with ctl_byte_o=0x11, and the block leaves the paused state.
- R9: ctl_req_o never stays high for two cycles in a row. There is no second pause request until a resume request has been issued, and no resume request without an earlier pause request. ctl_byte_o holds its last value while ctl_req_o is 0, and is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe from the receiver |
| wr_data_i | input | 8 | Byte to store |
| rd_en_i | input | 1 | Read strobe from the consumer |
| rd_data_o | output | 8 | Byte taken by the last accepted read |
| count_o | output | ADDR_W | Number of bytes held |
| empty_o | output | 1 | Buffer holds no bytes |
| full_o | output | 1 | Buffer holds 2**ADDR_W-1 bytes |
| ovf_o | output | 1 | Sticky flag: a write was dropped |
| hi_mark_i | input | ADDR_W | Fill level that triggers a pause request |
| lo_mark_i | input | ADDR_W | Fill level that triggers a resume request |
| ctl_req_o | output | 1 | One-cycle request to send a flow-control byte |
| ctl_byte_o | output | 8 | Flow-control byte that goes with the request |

## Verification
The bench fills the buffer to its last usable slot and then writes more, to show that those writes are dropped. A design that used every slot would report full one byte late, or overwrite the oldest byte. Reads from an empty buffer must leave the output byte and the count unchanged; a design that moved its pointer would corrupt later data. The bench pushes more than the store size through the buffer so that both pointers wrap, and it hovers the fill level around both marks. A design without a latched pause state would send pause characters again and again, or would send resume characters that were never preceded by a pause.

// File: rtl/rb_pkg.sv
package rb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [BYTE_W-1:0] {
        CTL_NONE  = 8'h00,
        CTL_RESUME = 8'h11,
        CTL_PAUSE  = 8'h13
    } ctl_code_e;

    typedef struct packed {
        logic req;
        ctl_code_e code;
    } ctl_msg_t;

endpackage

// File: rtl/rb_store.sv
module rb_store
    import rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] count,
    output logic              empty,
    output logic              full,
    output logic              ovf
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] head_q, tail_q, cnt_q;
    logic [BYTE_W-1:0] rd_q;
    logic              ovf_q;
    logic              wr_ok, rd_ok;

    assign empty = (head_q == tail_q);
    assign full  = ((tail_q + ADDR_W'(1)) == head_q);
    assign wr_ok = wr_en && !full;
    assign rd_ok = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[tail_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            rd_q   <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (wr_ok) tail_q <= tail_q + ADDR_W'(1);
            if (rd_ok) begin
                head_q <= head_q + ADDR_W'(1);
                rd_q   <= mem[head_q];
            end
            if (wr_ok && !rd_ok)      cnt_q <= cnt_q + ADDR_W'(1);
            else if (rd_ok && !wr_ok) cnt_q <= cnt_q - ADDR_W'(1);
            if (wr_en && full) ovf_q <= 1'b1;
        end
    end

    assign rd_data = rd_q;
    assign count   = cnt_q;
    assign ovf     = ovf_q;

    // R3: the occupancy moves by at most one per cycle
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + ADDR_W'(1))
                 || (count == $past(count) - ADDR_W'(1)));

    // R4: the two flags never agree on a non-degenerate store
    assert_flags_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    // R5: a write into a full store with no read leaves the level at the top
    assert_full_write_dropped_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> full && (count == $past(count)));

    // R5: the overflow flag is sticky
    assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R6: a read from an empty store keeps the output byte
    assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> rd_data == $past(rd_data));

endmodule

// File: rtl/rb_flow.sv
module rb_flow
    import rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] level,
    input  logic [ADDR_W-1:0] hi_mark,
    input  logic [ADDR_W-1:0] lo_mark,
    output ctl_msg_t          msg
);
    logic     paused_q;
    ctl_msg_t msg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            paused_q     <= 1'b0;
            msg_q.req    <= 1'b0;
            msg_q.code   <= CTL_NONE;
        end else begin
            msg_q.req <= 1'b0;
            if (!paused_q && level >= hi_mark) begin
                paused_q   <= 1'b1;
                msg_q.req  <= 1'b1;
                msg_q.code <= CTL_PAUSE;
            end else if (paused_q && level <= lo_mark) begin
                paused_q   <= 1'b0;
                msg_q.req  <= 1'b1;
                msg_q.code <= CTL_RESUME;
            end
        end
    end

    assign msg = msg_q;

    // R9: a request lasts a single cycle
    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        msg.req |=> !msg.req);

    // R7: a pause request always follows a level at or above the upper mark
    assert_pause_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (msg.req && msg.code == CTL_PAUSE) |-> $past(level) >= $past(hi_mark));

    // R8: a resume request always follows a level at or below the lower mark
    assert_resume_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (msg.req && msg.code == CTL_RESUME) |-> $past(level) <= $past(lo_mark));

    // R9: the code is held while no request is raised
    assert_code_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !msg.req |-> $stable(msg.code) || $past(rst));

endmodule

// File: rtl/rb_xonxoff_fifo.sv
module rb_xonxoff_fifo
    import rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_en_i,
    output logic [7:0]        rd_data_o,
    output logic [ADDR_W-1:0] count_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              ovf_o,
    input  logic [ADDR_W-1:0] hi_mark_i,
    input  logic [ADDR_W-1:0] lo_mark_i,
    output logic              ctl_req_o,
    output logic [7:0]        ctl_byte_o
);
    ctl_msg_t msg;

    rb_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_data (wr_data_i),
        .rd_en   (rd_en_i),
        .rd_data (rd_data_o),
        .count   (count_o),
        .empty   (empty_o),
        .full    (full_o),
        .ovf     (ovf_o)
    );

    rb_flow #(.ADDR_W(ADDR_W)) u_flow (
        .clk     (clk),
        .rst     (rst),
        .level   (count_o),
        .hi_mark (hi_mark_i),
        .lo_mark (lo_mark_i),
        .msg     (msg)
    );

    assign ctl_req_o  = msg.req;
    assign ctl_byte_o = msg.code;

endmodule

// File: tb/tb_rb_xonxoff_fifo.sv
module tb_rb_xonxoff_fifo;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic [AW-1:0] count;
    logic          empty, full, ovf, ctl_req;
    logic [7:0]    ctl_byte;
    logic [AW-1:0] hi_mark = AW'(200), lo_mark = AW'(50);

    always #10 clk = ~clk;

    rb_xonxoff_fifo #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_data_o(rd_data),
        .count_o(count), .empty_o(empty), .full_o(full), .ovf_o(ovf),
        .hi_mark_i(hi_mark), .lo_mark_i(lo_mark),
        .ctl_req_o(ctl_req), .ctl_byte_o(ctl_byte)
    );

    int checks = 0;
    int fails  = 0;
    int pauses = 0;
    int resumes = 0;
    bit done   = 0;

    logic [7:0] q[$];
    int         m_cnt = 0;
    logic [7:0] m_rd = 8'h00;
    bit         m_ovf = 0;
    bit         m_stop = 0;
    bit         m_req = 0;
    logic [7:0] m_byte = 8'h00;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 rd_data", rd_data, m_rd);
        chk("R3 count", count, m_cnt);
        chk("R4 empty", empty, m_cnt == 0);
        chk("R4 full", full, m_cnt == DEPTH - 1);
        chk("R5 overflow", ovf, m_ovf);
        chk("R7/R8 ctl_req", ctl_req, m_req);
        chk("R9 ctl_byte", ctl_byte, m_byte);
    endtask

    task automatic step(input bit w, input logic [7:0] d, input bit r);
        bit wacc, racc;
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        m_req = 0;
        if (!m_stop && m_cnt >= int'(hi_mark)) begin
            m_req = 1; m_byte = 8'h13; m_stop = 1; pauses++;
        end else if (m_stop && m_cnt <= int'(lo_mark)) begin
            m_req = 1; m_byte = 8'h11; m_stop = 0; resumes++;
        end
        wacc = w && (q.size() < DEPTH - 1);
        racc = r && (q.size() > 0);
        if (w && !wacc) m_ovf = 1;
        if (racc) m_rd = q.pop_front();
        if (wacc) q.push_back(d);
        m_cnt = q.size();
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        compare_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is still applied
        chk("R1 empty in reset", empty, 1);
        chk("R1 full in reset", full, 0);
        chk("R1 count in reset", count, 0);
        chk("R1 ovf in reset", ovf, 0);
        chk("R1 ctl_req in reset", ctl_req, 0);
        rst = 0;
        step(0, 0, 0);

        // R6: reads from an empty buffer are ignored
        step(0, 0, 1);
        step(0, 0, 1);
        // R2, R3: short bursts in order
        for (int i = 0; i < 5; i++) step(1, 8'(8'hA0 + i), 0);
        for (int i = 0; i < 3; i++) step(0, 0, 1);
        // R3: simultaneous read and write
        for (int i = 0; i < 4; i++) step(1, 8'(8'h30 + i), 1);
        for (int i = 0; i < 6; i++) step(0, 0, 1);
        step(0, 0, 1); // R6: empty again
        // R3: simultaneous on empty: only the write is taken
        step(1, 8'h5A, 1);
        step(0, 0, 1);

        // R7, R4, R5: fill to the top and past it
        for (int i = 0; i < DEPTH + 4; i++) step(1, 8'(i * 7 + 3), 0);
        chk("R4 full at top", full, 1);
        chk("R5 ovf after drop", ovf, 1);
        chk("R7 one pause so far", pauses, 1);
        // R5: write with read while full: write dropped, read taken
        step(1, 8'hEE, 1);
        step(0, 0, 0);
        // R8: drain to empty, pointers wrap
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1);
        chk("R8 one resume", resumes, 1);
        chk("R5 ovf sticky", ovf, 1);

        // R9: hover around the marks with tighter thresholds
        hi_mark = AW'(10); lo_mark = AW'(4);
        for (int i = 0; i < 12; i++) step(1, 8'(i + 8'h40), 0);
        for (int i = 0; i < 6; i++) begin
            step(0, 0, 1);
            step(1, 8'(i), 0);
        end
        chk("R9 single pause per excursion", pauses, 2);
        for (int i = 0; i < 10; i++) step(0, 0, 1);
        chk("R9 single resume per excursion", resumes, 2);

        // mixed traffic, wraps pointers again
        hi_mark = AW'(30); lo_mark = AW'(12);
        for (int i = 0; i < 3000; i++) begin
            int v = $urandom_range(0, 99);
            step(v < 55, 8'($urandom), (v % 3) != 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule